// File: doc/BRIEF.md
# Two-Level Branch Target Buffer

This block predicts the target address of a taken branch from its fetch address. It holds two set-associative tables: a small, fast first level and a second level with six times as many sets and the same number of ways. A lookup probes the first level and, only when that misses, the second level. Hit and target are returned combinationally in the cycle the lookup is presented, so fetch sees no bubble.

Resolved branches train the buffer through an update port. Allocation is staged. A branch seen for the first time is written only into the second level. A later update that misses the first level but finds the branch in the second level copies it into the first level with the newly resolved target. An update that hits the first level rewrites that entry's target in place. Updates from the wrong path are dropped unless a configuration input allows them. Every set in both levels keeps true least-recently-used order for victim choice.

Top module: `two_level_btb`

## Requirements
- R1: After reset every entry of both levels is invalid, so every lookup reports a miss.
- R2: A valid lookup returns the first-level target when the first level hits. Otherwise it returns the second-level target when the second level hits, and otherwise it reports a miss. The result is valid in the same cycle. An idle lookup reports no hit.
- R3: An accepted update whose address misses both levels allocates an entry only in the second level, holding the resolved target. The first level is unchanged.
- R4: An accepted update that misses the first level but hits the second allocates a first-level entry holding the resolved target. The second-level entry keeps its old target.
- R5: An accepted update that hits the first level overwrites that entry's target with the resolved target. The second level is not touched.
- R6: A victim way is the lowest-numbered invalid way, or else the least recently used way of the set. A lookup hit, and an update that writes an entry or hits in the second level, make that way the most recently used. When both occur in one set in one cycle, the lookup's refresh is applied first.
- R7: An update with the off-path flag set has no effect unless the off-path write enable is high.
- R8: A lookup in the same cycle as an update sees the contents from before that update.
- R9: The fetch address is divided by 4 (2 alignment bits). The set index is that word address modulo the level's set count, and the tag is the quotient. The default geometry is 4 sets by 2 ways in the first level and 24 sets by 2 ways in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Lookup fetch address |
| lk_hit_o | output | 1 | Lookup hit, same cycle |
| lk_target_o | output | 32 | Predicted target |
| up_valid_i | input | 1 | Update request |
| up_pc_i | input | 32 | Resolved branch fetch address |
| up_target_i | input | 32 | Resolved target |
| up_offpath_i | input | 1 | Update comes from a wrong-path branch |
| offpath_wr_en_i | input | 1 | Allow off-path updates to write |

## Verification
A lookup and an update can arrive in the same cycle, and they may fall on the same set. When they do, the lookup must read the old contents, and both recency refreshes must land in order. The bench provokes this in a directed step that looks up and trains a new address in one cycle, and in random traffic where one quarter of cycles reuse the update address for the lookup. A reference model of both levels judges each case. It takes its update decisions and victims from the state before the edge, then applies the lookup refresh before the update.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_TOUCH = 2'd1,  // refresh recency on hit only
    UPD_WRITE = 2'd2,  // overwrite target of hit way
    UPD_ALLOC = 2'd3   // allocate into victim way
  } upd_op_e;
endpackage

// File: rtl/btb_lru_set.sv
`timescale 1ns/1ps
module btb_lru_set #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         a_en_i,
  input  logic [WAY_W-1:0]             a_way_i,
  input  logic                         b_en_i,
  input  logic [WAY_W-1:0]             b_way_i,
  output logic [WAYS-1:0][WAY_W-1:0]   age_o
);
  typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

  ages_t age_q, age_mid, age_d;

  function automatic ages_t promote(input ages_t a, input logic [WAY_W-1:0] w);
    ages_t r;
    r = a;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == w)    r[i] = '0;
      else if (a[i] < a[w])  r[i] = a[i] + WAY_W'(1);
    end
    return r;
  endfunction

  // lookup refresh first, update refresh last
  always_comb begin
    age_mid = a_en_i ? promote(age_q, a_way_i) : age_q;
    age_d   = b_en_i ? promote(age_mid, b_way_i) : age_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;

  a_r6_update_is_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_en_i |=> age_q[$past(b_way_i)] == '0);
endmodule

// File: rtl/btb_level.sv
`timescale 1ns/1ps
module btb_level import btb_pkg::*; #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 2,
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WORD_W = ADDR_W - ALIGN,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ENT    = SETS * WAYS,
  localparam int ENT_W  = $clog2(ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_en_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_tgt_o,
  input  upd_op_e           up_op_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic [ADDR_W-1:0] up_tgt_i,
  output logic              up_hit_o
);
  logic              v_q   [ENT];
  logic [WORD_W-1:0] tag_q [ENT];
  logic [ADDR_W-1:0] tgt_q [ENT];
  logic [WAYS-1:0][WAY_W-1:0] age_w [SETS];

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] pc);
    logic [ADDR_W-1:0] wd;
    wd = pc >> ALIGN;
    return IDX_W'(wd % ADDR_W'(SETS));
  endfunction

  function automatic logic [WORD_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    logic [ADDR_W-1:0] wd;
    wd = pc >> ALIGN;
    return WORD_W'(wd / ADDR_W'(SETS));
  endfunction

  function automatic int ent(input logic [IDX_W-1:0] s, input int w);
    return int'(s) * WAYS + w;
  endfunction

  // lookup port
  logic [IDX_W-1:0]  lk_set;
  logic [WORD_W-1:0] lk_tag;
  logic [WAYS-1:0]   lk_hitv;
  logic [WAY_W-1:0]  lk_way;
  logic              lk_touch;

  always_comb begin
    lk_set   = set_of(lk_pc_i);
    lk_tag   = tag_of(lk_pc_i);
    lk_hitv  = '0;
    lk_way   = '0;
    lk_tgt_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v_q[ent(lk_set, w)] && tag_q[ent(lk_set, w)] == lk_tag) begin
        lk_hitv[w] = 1'b1;
        lk_way     = WAY_W'(w);
        lk_tgt_o   = tgt_q[ent(lk_set, w)];
      end
    end
  end

  assign lk_hit_o = lk_en_i && (|lk_hitv);
  assign lk_touch = lk_hit_o;

  // update port
  logic [IDX_W-1:0]  up_set;
  logic [WORD_W-1:0] up_tag;
  logic [WAYS-1:0]   up_hitv;
  logic [WAY_W-1:0]  up_way, vic_way, wr_way;
  logic              vic_found, do_write, up_touch;
  logic [ENT_W-1:0]  wr_idx;

  always_comb begin
    up_set  = set_of(up_pc_i);
    up_tag  = tag_of(up_pc_i);
    up_hitv = '0;
    up_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v_q[ent(up_set, w)] && tag_q[ent(up_set, w)] == up_tag) begin
        up_hitv[w] = 1'b1;
        up_way     = WAY_W'(w);
      end
    end
    // invalid way first, else oldest
    vic_way   = '0;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_found && !v_q[ent(up_set, w)]) begin
        vic_way   = WAY_W'(w);
        vic_found = 1'b1;
      end
    end
    if (!vic_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_w[up_set][w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
      end
    end
  end

  assign up_hit_o = |up_hitv;
  assign wr_way   = (up_op_i == UPD_ALLOC) ? vic_way : up_way;
  assign do_write = (up_op_i == UPD_ALLOC) || (up_op_i == UPD_WRITE && up_hit_o);
  assign up_touch = do_write || (up_op_i == UPD_TOUCH && up_hit_o);
  assign wr_idx   = ENT_W'(ent(up_set, int'(wr_way)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENT; e++) v_q[e] <= 1'b0;
    end else if (do_write) begin
      v_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_write) begin
      tag_q[wr_idx] <= up_tag;
      tgt_q[wr_idx] <= up_tgt_i;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_lru
    btb_lru_set #(.WAYS(WAYS)) u_lru (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_en_i  (lk_touch && lk_set == IDX_W'(s)),
      .a_way_i (lk_way),
      .b_en_i  (up_touch && up_set == IDX_W'(s)),
      .b_way_i (wr_way),
      .age_o   (age_w[s])
    );
  end

  a_r2_single_way_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hitv));

  a_r3_alloc_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_op_i == UPD_ALLOC) |=> v_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(up_tag));

  a_r5_target_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_write |=> tgt_q[$past(wr_idx)] == $past(up_tgt_i));
endmodule

// File: rtl/two_level_btb.sv
`timescale 1ns/1ps
module two_level_btb import btb_pkg::*; #(
  parameter int L1_SETS = 4,
  parameter int WAYS    = 2,
  parameter int ADDR_W  = 32,
  parameter int ALIGN   = 2,
  localparam int L2_SETS = 6 * L1_SETS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic [ADDR_W-1:0] up_target_i,
  input  logic              up_offpath_i,
  input  logic              offpath_wr_en_i
);
  logic              l1_lk_hit, l2_lk_hit, l1_up_hit, l2_up_hit, up_go;
  logic [ADDR_W-1:0] l1_tgt, l2_tgt;
  upd_op_e           l1_op, l2_op;

  btb_level #(.SETS(L1_SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_l1 (
    .clk_i, .rst_ni,
    .lk_en_i  (lk_valid_i),
    .lk_pc_i  (lk_pc_i),
    .lk_hit_o (l1_lk_hit),
    .lk_tgt_o (l1_tgt),
    .up_op_i  (l1_op),
    .up_pc_i  (up_pc_i),
    .up_tgt_i (up_target_i),
    .up_hit_o (l1_up_hit)
  );

  // level two probed only on a level-one miss
  btb_level #(.SETS(L2_SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_l2 (
    .clk_i, .rst_ni,
    .lk_en_i  (lk_valid_i && !l1_lk_hit),
    .lk_pc_i  (lk_pc_i),
    .lk_hit_o (l2_lk_hit),
    .lk_tgt_o (l2_tgt),
    .up_op_i  (l2_op),
    .up_pc_i  (up_pc_i),
    .up_tgt_i (up_target_i),
    .up_hit_o (l2_up_hit)
  );

  assign lk_hit_o    = l1_lk_hit || l2_lk_hit;
  assign lk_target_o = l1_lk_hit ? l1_tgt : (l2_lk_hit ? l2_tgt : '0);

  assign up_go = up_valid_i && (!up_offpath_i || offpath_wr_en_i);

  always_comb begin
    l1_op = UPD_NONE;
    l2_op = UPD_NONE;
    if (up_go) begin
      if (l1_up_hit) begin
        l1_op = UPD_WRITE;
      end else if (l2_up_hit) begin
        l1_op = UPD_ALLOC;  // promote
        l2_op = UPD_TOUCH;
      end else begin
        l2_op = UPD_ALLOC;  // first sighting
      end
    end
  end

  a_r2_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !lk_hit_o);

  a_r7_offpath_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_offpath_i && !offpath_wr_en_i) |-> (l1_op == UPD_NONE && l2_op == UPD_NONE));
endmodule

// File: tb/two_level_btb_bench.sv
`timescale 1ns/1ps
module two_level_btb_bench;
  localparam int L1S = 4;
  localparam int W   = 2;
  localparam int L2S = 6 * L1S;
  localparam int NE  = (L1S + L2S) * W;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0, up_valid_i = 1'b0, up_offpath_i = 1'b0, offpath_wr_en_i = 1'b0;
  logic [31:0] lk_pc_i = '0, up_pc_i = '0, up_target_i = '0;
  logic        lk_hit_o;
  logic [31:0] lk_target_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  two_level_btb u_two_level_btb (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
    .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
    .up_valid_i(up_valid_i), .up_pc_i(up_pc_i), .up_target_i(up_target_i),
    .up_offpath_i(up_offpath_i), .offpath_wr_en_i(offpath_wr_en_i)
  );

  // reference model: level 0 entries first, then level 1
  bit          m_v   [NE];
  int unsigned m_tag [NE];
  logic [31:0] m_tgt [NE];
  int          m_age [NE];

  function automatic int nsets(input int lvl);
    return (lvl == 0) ? L1S : L2S;
  endfunction
  function automatic int base(input int lvl);
    return (lvl == 0) ? 0 : L1S * W;
  endfunction
  function automatic int setof(input int lvl, input logic [31:0] pc);
    return int'((pc >> 2) % nsets(lvl));
  endfunction
  function automatic int unsigned tagof(input int lvl, input logic [31:0] pc);
    return (pc >> 2) / nsets(lvl);
  endfunction
  function automatic int idx(input int lvl, input int s, input int w);
    return base(lvl) + s * W + w;
  endfunction
  function automatic int probe(input int lvl, input logic [31:0] pc);
    int s = setof(lvl, pc);
    for (int w = 0; w < W; w++)
      if (m_v[idx(lvl, s, w)] && m_tag[idx(lvl, s, w)] == tagof(lvl, pc)) return w;
    return -1;
  endfunction
  function automatic int victim(input int lvl, input int s);
    for (int w = 0; w < W; w++) if (!m_v[idx(lvl, s, w)]) return w;
    for (int w = 0; w < W; w++) if (m_age[idx(lvl, s, w)] == W - 1) return w;
    return 0;
  endfunction
  function automatic void touch(input int lvl, input int s, input int w);
    int old = m_age[idx(lvl, s, w)];
    for (int i = 0; i < W; i++) begin
      if (i == w) m_age[idx(lvl, s, i)] = 0;
      else if (m_age[idx(lvl, s, i)] < old) m_age[idx(lvl, s, i)]++;
    end
  endfunction
  function automatic void put(input int lvl, input int s, input int w, input logic [31:0] pc, input logic [31:0] t);
    m_v[idx(lvl, s, w)]   = 1'b1;
    m_tag[idx(lvl, s, w)] = tagof(lvl, pc);
    m_tgt[idx(lvl, s, w)] = t;
    touch(lvl, s, w);
  endfunction
  function automatic void model_reset();
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < nsets(l); s++)
        for (int w = 0; w < W; w++) begin
          m_v[idx(l, s, w)]   = 1'b0;
          m_age[idx(l, s, w)] = w;
        end
  endfunction

  task automatic step(input bit lv, input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input logic [31:0] ut, input bit off, input bit allow, input string req);
    int h1, h2, u1, u2, v1, v2;
    bit eh, go;
    logic [31:0] et;
    @(negedge clk);
    lk_valid_i = lv; lk_pc_i = lpc; up_valid_i = uv; up_pc_i = upc;
    up_target_i = ut; up_offpath_i = off; offpath_wr_en_i = allow;
    #1;
    h1 = probe(0, lpc);
    h2 = probe(1, lpc);
    eh = lv && (h1 >= 0 || h2 >= 0);
    et = (h1 >= 0) ? m_tgt[idx(0, setof(0, lpc), h1)] :
         (h2 >= 0) ? m_tgt[idx(1, setof(1, lpc), h2)] : 32'h0;
    n_chk++;
    if (lk_hit_o !== eh || (eh && lk_target_o !== et)) begin
      n_fail++;
      $display("FAIL %s pc=%h hit=%b tgt=%h expected hit=%b tgt=%h", req, lpc, lk_hit_o, lk_target_o, eh, et);
    end
    // update decisions come from pre-edge state
    go = uv && (!off || allow);
    u1 = probe(0, upc);
    u2 = probe(1, upc);
    v1 = victim(0, setof(0, upc));
    v2 = victim(1, setof(1, upc));
    @(posedge clk);
    if (lv) begin
      if (h1 >= 0) touch(0, setof(0, lpc), h1);
      else if (h2 >= 0) touch(1, setof(1, lpc), h2);
    end
    if (go) begin
      if (u1 >= 0) put(0, setof(0, upc), u1, upc, ut);
      else if (u2 >= 0) begin
        touch(1, setof(1, upc), u2);
        put(0, setof(0, upc), v1, upc, ut);
      end else put(1, setof(1, upc), v2, upc, ut);
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(1'b1, pc, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, req);
  endtask
  task automatic train(input logic [31:0] pc, input logic [31:0] t, input bit off, input bit allow, input string req);
    step(1'b0, 32'h0, 1'b1, pc, t, off, allow, req);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] PA = 32'h4, PB = 32'h14, PC = 32'h24, PD = 32'h40, PE = 32'h48, PF = 32'h64;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: cold state
    for (int i = 0; i < 8; i++) look(32'(i * 4), "R1");
    step(1'b0, PA, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, "R2");

    // R3: first sighting goes to level two only
    train(PA, 32'h1000, 1'b0, 1'b0, "R3");
    look(PA, "R3");
    // R4: promotion with new target, level two keeps old one
    train(PA, 32'h2000, 1'b0, 1'b0, "R4");
    look(PA, "R4");
    // R5: level-one overwrite
    train(PA, 32'h3000, 1'b0, 1'b0, "R5");
    look(PA, "R5");
    // R6: fill level-one set 1 so PA is evicted, then level two answers
    train(PB, 32'h4000, 1'b0, 1'b0, "R6");
    train(PB, 32'h4100, 1'b0, 1'b0, "R6");
    train(PC, 32'h5000, 1'b0, 1'b0, "R6");
    train(PC, 32'h5100, 1'b0, 1'b0, "R6");
    look(PA, "R6");
    look(PB, "R6");
    look(PC, "R6");
    // R7: off-path suppression and override
    train(PD, 32'h6000, 1'b1, 1'b0, "R7");
    look(PD, "R7");
    train(PD, 32'h6000, 1'b1, 1'b1, "R7");
    look(PD, "R7");
    // R8: same-cycle lookup and update of the same address
    step(1'b1, PE, 1'b1, PE, 32'h7000, 1'b0, 1'b0, "R8");
    look(PE, "R8");
    // R9: same level-two set as PA, different tag
    look(PF, "R9");
    train(PF, 32'h8000, 1'b0, 1'b0, "R9");
    look(PF, "R9");
    look(PA, "R9");

    // constrained random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit lv, uv, off, al;
      logic [31:0] lpc, upc, ut;
      lv  = ($urandom % 4) != 0;
      uv  = ($urandom % 2) != 0;
      off = ($urandom % 4) == 0;
      al  = ($urandom % 2) != 0;
      upc = ($urandom % 160) << 2;
      lpc = (($urandom % 4) == 0) ? upc : (($urandom % 160) << 2);
      ut  = $urandom & 32'hffff_fffc;
      step(lv, lpc, uv, upc, ut, off, al, (lpc == upc && uv) ? "R8" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule